// File: doc/BRIEF.md
# Dual-Port Serial Sample Deserializer with Mix Multiply

The block takes two serial bit streams, one bit per rising clock edge. The clock is the bit clock. One stream carries data samples and the other carries mix factors. Each port has its own framing pulse, which is high during the first bit of a word. A port collects bits until the programmed word length is reached and then turns the bits into a signed, sign-extended word.

A finished mix word goes into a holding register and stays there until the next mix word completes. Each finished sample is multiplied by the held mix factor. The full-precision product goes to a downstream filter stage, marked by a single-cycle valid strobe.

One set of configuration inputs applies to both ports:
- word length, from 8 to 24 bits;
- bit order, most-significant bit first or least-significant bit first;
- number format, two's complement or offset binary.

A framing pulse that arrives partway through a word discards the partial word and starts a new one.

Top module: `ser_mix_rx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `prod_valid` is 0 after that edge and `prod` is 0.
- R2: With `cfg_len` = L (8 to 24), a word is the bit captured with its port's sync high plus the next L-1 bits. The resulting product covers every length in that range.
- R3: With `cfg_lsb_first` = 0, the first bit received is bit L-1 of the word. With `cfg_lsb_first` = 1, the first bit received is bit 0.
- R4: With `cfg_offset_bin` = 0, a word is L-bit two's complement. With `cfg_offset_bin` = 1, a word is offset binary and is converted by inverting bit L-1. Either way, the value is then sign-extended from bit L-1 to 24 bits.
- R5: The mix port frames its words with `mix_sync` and uses the same configuration as the sample port. `prod` equals sample times mix factor as a signed 48-bit product. A completed mix word on its own raises no `prod_valid`.
- R6: The most recently completed mix factor is used for every sample until another mix word completes. Before the first mix word, the mix factor is 0.
- R7: Suppose the final bit of a sample is captured at edge E. Then `prod_valid` is 1 after edge E+1 and 0 after edge E+2. `prod` keeps its value until the next strobe.
- R8: A sync pulse during an unfinished word discards that word, and the bit count restarts with the current bit as bit one.
- R9: Bits received while no word is in progress and sync is low have no effect on outputs or on the held mix factor.
- R10: A `cfg_len` below 8 acts as 8, and a `cfg_len` above 24 acts as 24.
- R11: When a sample and a mix word complete at the same edge, the product uses the new mix factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit per port per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 5 | Word length in bits, clamped to 8..24 |
| cfg_lsb_first | input | 1 | 0: MSB first, 1: LSB first |
| cfg_offset_bin | input | 1 | 0: two's complement, 1: offset binary |
| din | input | 1 | Sample serial data |
| din_sync | input | 1 | High on the first bit of a sample word |
| mix_din | input | 1 | Mix factor serial data |
| mix_sync | input | 1 | High on the first bit of a mix word |
| prod | output | 48 | Signed sample times mix product |
| prod_valid | output | 1 | One-cycle strobe for a new product |

## Verification
The bench builds the block with its default parameters: minimum length 8, maximum length 24, and a 48-bit product. At these values every word length from 8 to 24 can be swept in full, under all four order and format combinations.

For each combination the bench sends one mix word and then five sample values: zero, the largest positive code, the most negative code, all ones, and a mixed pattern. This reaches the sign-extension and format-inversion corners at every length. Further cases cover:
- framing pulses during an unfinished word;
- idle bit noise;
- out-of-range length codes;
- a mix word and a sample finishing on the same edge.

// File: rtl/ser_mix_pkg.sv
// Package: shared enumerations for the serial mixing deserializer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package ser_mix_pkg;

    typedef enum logic {
        ORD_MSB_FIRST = 1'b0,
        ORD_LSB_FIRST = 1'b1
    } bit_order_e;

    typedef enum logic {
        FMT_TWOS   = 1'b0,
        FMT_OFFSET = 1'b1
    } num_fmt_e;

endpackage

// File: rtl/ser_word_rx.sv
// Module: ser_word_rx
// Collects one serially framed word per sync pulse, one bit per clock.
// Once the programmed number of bits has arrived, the word is converted
// to two's complement, sign-extended to MAX_W bits, and registered.
// done_o pulses for one cycle. word_o holds its value until the next
// word completes.
// Assumes: configuration is stable while a word is being received.
module ser_word_rx
    import ser_mix_pkg::*;
#(
    parameter int MIN_W = 8,
    parameter int MAX_W = 24,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LEN_W-1:0]        cfg_len,
    input  bit_order_e              cfg_ord,
    input  num_fmt_e                cfg_fmt,
    input  logic                    ser_bit,
    input  logic                    ser_sync,
    output logic signed [MAX_W-1:0] word_o,
    output logic                    done_o
);

    logic [MAX_W-1:0] sr_q, sr_nxt;
    logic [LEN_W-1:0] cnt_q, cnt_nxt;
    logic             act_q, act_nxt;
    logic             finish;
    logic [LEN_W-1:0] eff_len;
    logic signed [MAX_W-1:0] word_q;
    logic             done_q;

    // Clamp the programmed length into the supported range.
    always_comb begin
        if (cfg_len < LEN_W'(MIN_W))      eff_len = LEN_W'(MIN_W);
        else if (cfg_len > LEN_W'(MAX_W)) eff_len = LEN_W'(MAX_W);
        else                              eff_len = cfg_len;
    end

    // Turn the raw bits into a sign-extended two's complement value.
    function automatic logic signed [MAX_W-1:0] shape_word(
        input logic [MAX_W-1:0] raw,
        input logic [LEN_W-1:0] n,
        input logic             offs
    );
        logic [MAX_W-1:0] r;
        logic             sgn;
        r = raw;
        r[n - 1'b1] = r[n - 1'b1] ^ offs;
        sgn = r[n - 1'b1];
        for (int i = 0; i < MAX_W; i++) begin
            if (i >= int'(n)) r[i] = sgn;
        end
        return $signed(r);
    endfunction

    // Next-state logic: restart on sync, otherwise shift while a word is open.
    always_comb begin
        sr_nxt  = sr_q;
        cnt_nxt = cnt_q;
        act_nxt = act_q;
        finish  = 1'b0;
        if (ser_sync) begin
            sr_nxt    = '0;
            sr_nxt[0] = ser_bit;
            cnt_nxt   = LEN_W'(1);
            act_nxt   = 1'b1;
        end else if (act_q) begin
            if (cfg_ord == ORD_LSB_FIRST) sr_nxt[cnt_q] = ser_bit;
            else                          sr_nxt = {sr_q[MAX_W-2:0], ser_bit};
            cnt_nxt = cnt_q + 1'b1;
            if (cnt_nxt == eff_len) begin
                finish  = 1'b1;
                act_nxt = 1'b0;
            end
        end
    end

    // Register the framing state and capture each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            act_q  <= 1'b0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            sr_q   <= sr_nxt;
            cnt_q  <= cnt_nxt;
            act_q  <= act_nxt;
            done_q <= finish;
            if (finish) word_q <= shape_word(sr_nxt, eff_len, cfg_fmt == FMT_OFFSET);
        end
    end

    assign word_o = word_q;
    assign done_o = done_q;

    // R8: a sync bit always opens a fresh word at bit count one.
    a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sync |=> (act_q && cnt_q == LEN_W'(1)));

    // R2: an open word never holds as many bits as the length.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> (cnt_q < eff_len));

    // R6: the held word changes only together with a completion.
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_q) |-> done_q);

    // R7: completions never fall on back-to-back cycles.
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

endmodule

// File: rtl/mix_product.sv
// Module: mix_product
// Multiplies each finished sample by the held mix factor and registers
// the full-precision product together with a one-cycle valid strobe.
// Assumes: samp_done_i is a single-cycle pulse.
module mix_product #(
    parameter int MAX_W  = 24,
    parameter int PROD_W = 2 * MAX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [MAX_W-1:0]  samp_i,
    input  logic                     samp_done_i,
    input  logic signed [MAX_W-1:0]  mix_i,
    output logic signed [PROD_W-1:0] prod_o,
    output logic                     valid_o
);

    logic signed [PROD_W-1:0] prod_q;
    logic                     valid_q;

    // Form and hold the product when a sample completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= samp_done_i;
            if (samp_done_i) prod_q <= PROD_W'(samp_i) * PROD_W'(mix_i);
        end
    end

    assign prod_o  = prod_q;
    assign valid_o = valid_q;

    // R7: the strobe lasts exactly one cycle.
    a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R7: the product only changes alongside the strobe.
    a_r7_prod_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prod_q) |-> valid_q);

endmodule

// File: rtl/ser_mix_rx.sv
// Module: ser_mix_rx (top)
// Two independently framed serial receivers: one for samples, one for
// mix factors. The finished mix word doubles as the holding register.
// Each finished sample is multiplied by it.
// Assumes: one bit per port per clock; shared configuration is stable
// while words are in progress.
module ser_mix_rx
    import ser_mix_pkg::*;
#(
    parameter  int MIN_W  = 8,
    parameter  int MAX_W  = 24,
    localparam int LEN_W  = $clog2(MAX_W + 1),
    localparam int PROD_W = 2 * MAX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_lsb_first,
    input  logic              cfg_offset_bin,
    input  logic              din,
    input  logic              din_sync,
    input  logic              mix_din,
    input  logic              mix_sync,
    output logic [PROD_W-1:0] prod,
    output logic              prod_valid
);

    bit_order_e              ord;
    num_fmt_e                fmt;
    logic signed [MAX_W-1:0] samp_word, mix_word;
    logic                    samp_done, mix_done;
    logic signed [PROD_W-1:0] prod_s;

    assign ord = bit_order_e'(cfg_lsb_first);
    assign fmt = num_fmt_e'(cfg_offset_bin);

    ser_word_rx #(.MIN_W(MIN_W), .MAX_W(MAX_W), .LEN_W(LEN_W)) samp_rx_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ord(ord), .cfg_fmt(fmt),
        .ser_bit(din), .ser_sync(din_sync), .word_o(samp_word), .done_o(samp_done)
    );

    ser_word_rx #(.MIN_W(MIN_W), .MAX_W(MAX_W), .LEN_W(LEN_W)) mix_rx_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_ord(ord), .cfg_fmt(fmt),
        .ser_bit(mix_din), .ser_sync(mix_sync), .word_o(mix_word), .done_o(mix_done)
    );

    mix_product #(.MAX_W(MAX_W), .PROD_W(PROD_W)) prod_i (
        .clk(clk), .rst_n(rst_n), .samp_i(samp_word), .samp_done_i(samp_done),
        .mix_i(mix_word), .prod_o(prod_s), .valid_o(prod_valid)
    );

    assign prod = prod_s;

    // R5: a strobe is always caused by a sample completion, never by a mix word.
    a_r5_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
        prod_valid |-> $past(samp_done));

endmodule

// File: tb/ser_mix_rx_tb.sv
// Bench: sweeps every length, order and format, plus the framing corner cases.
module ser_mix_rx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_len = 5'd8;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_offset_bin = 1'b0;
    logic        din = 1'b0, din_sync = 1'b0, mix_din = 1'b0, mix_sync = 1'b0;
    logic [47:0] prod;
    logic        prod_valid;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;
    longint cur_mix = 0;

    always #2.5 clk = ~clk;

    ser_mix_rx dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_lsb_first(cfg_lsb_first),
        .cfg_offset_bin(cfg_offset_bin), .din(din), .din_sync(din_sync),
        .mix_din(mix_din), .mix_sync(mix_sync), .prod(prod), .prod_valid(prod_valid)
    );

    task automatic chk(input string req, input bit ok, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Value of an n-bit word in the selected format.
    function automatic longint ref_val(input logic [23:0] raw, input int n, input bit offs);
        longint v;
        v = longint'(raw) & ((longint'(1) << n) - 1);
        if (offs) v = v ^ (longint'(1) << (n - 1));
        if (v >= (longint'(1) << (n - 1))) v = v - (longint'(1) << n);
        return v;
    endfunction

    function automatic logic bit_at(input logic [23:0] raw, input int n, input int i, input bit lsb);
        return lsb ? raw[i] : raw[n - 1 - i];
    endfunction

    task automatic drive(input logic sb, input logic ss, input logic mb, input logic ms);
        @(negedge clk);
        din = sb; din_sync = ss; mix_din = mb; mix_sync = ms;
    endtask

    // Send a sample of n bits and check the strobe and product timing.
    task automatic send_sample(input logic [23:0] raw, input int n, input string req);
        longint e;
        for (int i = 0; i < n; i++) drive(bit_at(raw, n, i, cfg_lsb_first), i == 0, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        e = ref_val(raw, n, cfg_offset_bin) * cur_mix;
        chk({req, " R7 valid"}, prod_valid == 1'b1, longint'(prod_valid), 1);
        chk({req, " product"}, longint'($signed(prod)) == e, longint'($signed(prod)), e);
        @(negedge clk);
        chk("R7 strobe drop", prod_valid == 1'b0, longint'(prod_valid), 0);
    endtask

    task automatic send_mix(input logic [23:0] raw, input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 1'b0, bit_at(raw, n, i, cfg_lsb_first), i == 0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5 no strobe on mix", prod_valid == 1'b0, longint'(prod_valid), 0);
        cur_mix = ref_val(raw, n, cfg_offset_bin);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] raw, mraw;
        bit seen;
        repeat (4) @(negedge clk);
        chk("R1 valid in reset", prod_valid == 1'b0, longint'(prod_valid), 0);
        chk("R1 prod in reset", prod == 48'd0, longint'(prod), 0);
        rst_n = 1'b1;

        // R6: before any mix word the factor is zero.
        cfg_len = 5'd12;
        send_sample(24'h7A5, 12, "R6 zero mix");

        // Full sweep of lengths, orders and formats.
        for (int len = 8; len <= 24; len++) begin
            for (int o = 0; o < 2; o++) begin
                for (int f = 0; f < 2; f++) begin
                    string tag;
                    cfg_len = 5'(len); cfg_lsb_first = o[0]; cfg_offset_bin = f[0];
                    tag = {"R2 R5", (o != 0) ? " R3" : "", (f != 0) ? " R4" : ""};
                    mraw = 24'((len * 37 + o * 5 + f * 11) * 24'h01F3 + 24'h5A3);
                    send_mix(mraw, len);
                    for (int k = 0; k < 5; k++) begin
                        case (k)
                            0: raw = 24'd0;
                            1: raw = 24'((longint'(1) << (len - 1)) - 1);
                            2: raw = 24'(longint'(1) << (len - 1));
                            3: raw = 24'hFFFFFF;
                            default: raw = 24'h5A3C96;
                        endcase
                        send_sample(raw, len, tag);
                    end
                end
            end
        end

        // R6: held factor reused for several samples.
        cfg_len = 5'd16; cfg_lsb_first = 1'b0; cfg_offset_bin = 1'b0;
        send_mix(24'hC123, 16);
        send_sample(24'h0101, 16, "R6 hold 1");
        send_sample(24'h8F00, 16, "R6 hold 2");

        // R8: partial word abandoned by a fresh sync.
        for (int i = 0; i < 6; i++) drive(1'b1, i == 0, 1'b0, 1'b0);
        send_sample(24'h3579, 16, "R8 restart");

        // R9: unframed bits on both lines change nothing.
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            drive(1'(i % 3 == 0), 1'b0, 1'(i % 2), 1'b0);
            if (prod_valid) seen = 1'b1;
        end
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R9 no strobe on idle bits", seen == 1'b0, longint'(seen), 0);
        send_sample(24'h1234, 16, "R9 mix unchanged");

        // R10: out-of-range lengths clamp.
        cfg_len = 5'd3;
        send_mix(24'h9C, 8);
        send_sample(24'hE7, 8, "R10 low clamp");
        cfg_len = 5'd31;
        send_mix(24'h800001, 24);
        send_sample(24'h7FFFFE, 24, "R10 high clamp");

        // R11: sample and mix finish on the same edge.
        cfg_len = 5'd10; cfg_lsb_first = 1'b1; cfg_offset_bin = 1'b1;
        raw = 24'h2C5; mraw = 24'h13A;
        for (int i = 0; i < 10; i++) drive(raw[i], i == 0, mraw[i], i == 0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        begin
            longint e;
            e = ref_val(raw, 10, 1'b1) * ref_val(mraw, 10, 1'b1);
            chk("R11 valid", prod_valid == 1'b1, longint'(prod_valid), 1);
            chk("R11 new mix used", longint'($signed(prod)) == e, longint'($signed(prod)), e);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule